// File: doc/BRIEF.md
# Comparator Output Edge Interrupt Controller

This block is the digital side of a single analog voltage comparator. The comparator's decision arrives as one asynchronous bit. The block brings that bit into the system clock domain and watches it for rising and falling transitions. Each kind of transition has its own sticky flag, and software clears a flag by writing zero to it. The block also passes the synchronized result on toward a routed output pin and raises an interrupt request from the flags.

Software reaches the block through one byte-wide control register, written through `wr_en`/`wr_data` and read on `ctrl_rd`. The register holds an on/off bit, a read-only live view of the synchronized output, the two edge flags and two 2-bit hysteresis codes. The hysteresis codes are stored here and driven out to the analog macro; they have no effect on the digital logic. While the block is switched off, the routed output stays low and no interrupt can be raised.

Top module: `cmp_edge_ctl`

## Requirements
- R1: The live output bit (ctrl_rd[6]) and, while enabled, `cmp_out` equal the value `cmp_raw` had two rising clock edges earlier.
- R2: While enabled, a 0-to-1 change of the synchronized output sets the rising flag (ctrl_rd[5]) at the third clock edge after `cmp_raw` changed.
- R3: While enabled, a 1-to-0 change of the synchronized output sets the falling flag (ctrl_rd[4]) at the third clock edge after `cmp_raw` changed.
- R4: A set flag stays set until a register write carries 0 in its bit position. A write that carries 1 there leaves the flag unchanged.
- R5: If a flag is set by an edge and cleared by a write at the same clock edge, the flag ends up set.
- R6: The enable bit is ctrl_rd[7] and is loaded from wr_data[7]. While it is 0, `cmp_out` is low, `irq` is low and no flag is set.
- R7: `irq` is high exactly when the block is enabled and either the rising flag is set with `rise_irq_en` high, or the falling flag is set with `fall_irq_en` high.
- R8: wr_data[3:2] is stored as the positive hysteresis code and wr_data[1:0] as the negative code. They read back on ctrl_rd[3:0] and appear on `hyst_pos` and `hyst_neg`.
- R9: After reset, all register bits read 0 and `irq` and `cmp_out` are low.
- R10: Turning the block on while the comparator output has been steady does not set either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw asynchronous comparator decision |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rise_irq_en | input | 1 | Allow the rising flag to request an interrupt |
| fall_irq_en | input | 1 | Allow the falling flag to request an interrupt |
| ctrl_rd | output | 8 | Control register read value |
| cmp_out | output | 1 | Synchronized output toward the routed pin |
| hyst_pos | output | 2 | Positive-going hysteresis code |
| hyst_neg | output | 2 | Negative-going hysteresis code |
| irq | output | 1 | Interrupt request |

## Verification
If the synchronizer or the edge history is wrong, the error shows up at the ports within three clock edges of a comparator change. It appears as a shifted ctrl_rd[6], as a flag that sets early, late or on the wrong polarity, or as a flag that sets falsely right after the block is turned on. If the flag update logic is wrong, a flag gets lost when a clear collides with an edge, or a write of 1 changes a flag it should leave alone. Both cases are visible on the next read and on `irq` in the same cycle. If the enable gating is wrong, `cmp_out` or `irq` goes high while the block is off.

// File: rtl/cmp_edge_ctl.sv
module cmp_edge_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_raw,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rise_irq_en,
  input  logic       fall_irq_en,
  output logic [7:0] ctrl_rd,
  output logic       cmp_out,
  output logic [1:0] hyst_pos,
  output logic [1:0] hyst_neg,
  output logic       irq
);

  logic       sync_a, sync_b, hist;
  logic       on;
  logic       rise_flag, fall_flag;
  logic [3:0] hyst;
  logic       rise_hit, fall_hit;

  assign rise_hit = on &  sync_b & ~hist;
  assign fall_hit = on & ~sync_b &  hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      hist   <= 1'b0;
    end else begin
      sync_a <= cmp_raw;
      sync_b <= sync_a;
      hist   <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on        <= 1'b0;
      hyst      <= 4'h0;
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        on   <= wr_data[7];
        hyst <= wr_data[3:0];
      end
      rise_flag <= rise_hit | (rise_flag & ~(wr_en & ~wr_data[5]));
      fall_flag <= fall_hit | (fall_flag & ~(wr_en & ~wr_data[4]));
    end
  end

  assign ctrl_rd  = {on, sync_b, rise_flag, fall_flag, hyst};
  assign cmp_out  = on & sync_b;
  assign hyst_pos = hyst[3:2];
  assign hyst_neg = hyst[1:0];
  assign irq      = on & ((rise_flag & rise_irq_en) | (fall_flag & fall_irq_en));

  a_r6_out_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[7] |-> !cmp_out);

  a_r6_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[7] |-> !irq);

  a_r6_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !rise_flag) |=> !rise_flag);

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (on && sync_b && !hist) |=> rise_flag);

  a_r3_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !sync_b && hist) |=> fall_flag);

  a_r4_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_flag && !(wr_en && !wr_data[5])) |=> rise_flag);

  a_r4_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_flag && !(wr_en && !wr_data[4])) |=> fall_flag);

  a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_rd[5] || ctrl_rd[4]));

  a_r8_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_rd[3:0]));

endmodule

// File: tb/cmp_edge_ctl_test.sv
module cmp_edge_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rise_irq_en = 1'b0;
  logic       fall_irq_en = 1'b0;
  logic [7:0] ctrl_rd;
  logic       cmp_out;
  logic [1:0] hyst_pos, hyst_neg;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit auto_chk = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_edge_ctl uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en), .wr_data(wr_data),
    .rise_irq_en(rise_irq_en), .fall_irq_en(fall_irq_en), .ctrl_rd(ctrl_rd),
    .cmp_out(cmp_out), .hyst_pos(hyst_pos), .hyst_neg(hyst_neg), .irq(irq)
  );

  // reference model, written from the requirements
  logic       m1, m2, m3, men, mrf, mff;
  logic [3:0] mhy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 0; m2 <= 0; m3 <= 0; men <= 0; mrf <= 0; mff <= 0; mhy <= 0;
    end else begin
      m1 <= cmp_raw;
      m2 <= m1;
      m3 <= m2;
      if (wr_en) begin men <= wr_data[7]; mhy <= wr_data[3:0]; end
      mrf <= (men && m2 && !m3) ? 1'b1 : ((wr_en && !wr_data[5]) ? 1'b0 : mrf);
      mff <= (men && !m2 && m3) ? 1'b1 : ((wr_en && !wr_data[4]) ? 1'b0 : mff);
    end
  end

  function automatic logic [7:0] exp_rd();
    return {men, m2, mrf, mff, mhy};
  endfunction

  function automatic logic exp_irq();
    return men & ((mrf & rise_irq_en) | (mff & fall_irq_en));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (auto_chk && rst_n) begin
      chk("R1 R2 R3 R4 R5 R6 R8 ctrl_rd", ctrl_rd, exp_rd());
      chk("R1 R6 cmp_out", {7'd0, cmp_out}, {7'd0, men & m2});
      chk("R7 irq", {7'd0, irq}, {7'd0, exp_irq()});
      chk("R8 hyst ports", {4'd0, hyst_pos, hyst_neg}, {4'd0, mhy});
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R9 reset state
    chk("R9 reset ctrl_rd", ctrl_rd, 8'h00);
    chk("R9 reset irq/cmp_out", {6'd0, irq, cmp_out}, 8'h00);
    auto_chk = 1'b1;

    // R10: steady high while off, then enable
    cmp_raw = 1'b1;
    step(5);
    chk("R6 off output low", {7'd0, cmp_out}, 8'h00);
    wr(8'h80);
    step(5);
    chk("R10 no spurious flags on enable", {6'd0, ctrl_rd[5:4]}, 8'h00);
    chk("R1 live bit high", {7'd0, ctrl_rd[6]}, 8'h01);

    // R3 falling edge latency
    cmp_raw = 1'b0;
    step(2);
    chk("R3 flag not yet set", {7'd0, ctrl_rd[4]}, 8'h00);
    step(1);
    chk("R3 falling flag set", {7'd0, ctrl_rd[4]}, 8'h01);

    // R4: write 1 keeps, write 0 clears
    wr(8'h9A);
    chk("R4 write 1 keeps flag", {7'd0, ctrl_rd[4]}, 8'h01);
    chk("R8 hyst readback", {4'd0, ctrl_rd[3:0]}, 8'h0A);
    wr(8'h8A);
    chk("R4 write 0 clears flag", {7'd0, ctrl_rd[4]}, 8'h00);

    // R5: rising set collides with a clear
    cmp_raw = 1'b1;
    step(2);
    wr(8'h85);
    chk("R5 set wins over clear", {7'd0, ctrl_rd[5]}, 8'h01);
    chk("R2 rising flag set", {7'd0, ctrl_rd[5]}, 8'h01);

    // R7 irq enables
    rise_irq_en = 1'b1;
    step(1);
    chk("R7 irq with rise enable", {7'd0, irq}, 8'h01);
    rise_irq_en = 1'b0;
    step(1);
    chk("R7 irq masked", {7'd0, irq}, 8'h00);

    // R6: disabled, edges ignored
    wr(8'h05);
    wr(8'h05);
    chk("R6 flags cleared while off", {6'd0, ctrl_rd[5:4]}, 8'h00);
    cmp_raw = 1'b0; step(4);
    cmp_raw = 1'b1; step(4);
    chk("R6 no flag set while off", {6'd0, ctrl_rd[5:4]}, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cmp_raw = ($urandom_range(0, 3) == 0) ? ~cmp_raw : cmp_raw;
      rise_irq_en = $urandom_range(0, 1);
      fall_irq_en = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1'b1;
        wr_data = $urandom_range(0, 255);
        if ($urandom_range(0, 3) != 0) wr_data[7] = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      step(1);
    end
    wr_en = 1'b0;
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule